// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block derives CAN time quanta from the system clock and walks each nominal bit through three phases: a one-quantum sync phase, a first timing segment that ends at the sample point, and a second timing segment that ends the bit. It emits a one-cycle quantum tick, a one-cycle sample strobe at the end of the first segment and a one-cycle bit-end strobe at the end of the second. A protocol engine uses the sample strobe to latch the receive line and the bit-end strobe to advance its bit stream.

Timing comes from one 32-bit configuration register. The register holds a prescaler, the two segment lengths and a jump width. Each length is stored as its value minus one. Writes are gated per byte. A receive-edge pulse from the line's recessive-to-dominant detector, qualified by a bus-idle level, drives two things: hard synchronisation while the bus is idle, and bounded phase correction during a frame. The block has no streaming data path, so every pin is a plain control or status level or pulse.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the configuration reads 0x00000000, `cfg_err` is 1, and no quantum tick, sample strobe or bit-end strobe occurs.
- R2: A write updates byte lane k (bits 8k+7:8k) only when `cfg_be[k]` is 1. The field positions are: prescaler P at bits 9:0, segment-1 code at 19:16, segment-2 code at 22:20, jump-width code at 25:24. All other bits always read 0.
- R3: `cfg_err` is 1 while the segment-1 code is 0, 1 or 2, or the segment-2 code is 0. While it is 1, no tick or strobe occurs and the bit position is held at the start of the sync phase.
- R4: With legal codes, a quantum lasts P+1 clocks. Segment 1 lasts code+1 quanta and segment 2 lasts code+1 quanta. Counting clocks from the cycle after the write, the sample strobe falls in the tick that ends quantum 1+L1, and the bit-end strobe falls in the tick that ends quantum 1+L1+L2. Bits then repeat with no gap.
- R5: A receive edge while `bus_idle` is 1 restarts the bit. The next cycle is the first clock of the sync quantum, with the prescaler cleared.
- R6: During a frame, an edge in segment 1 that is the first correction of the bit lengthens segment 1 by min(q+1, SJW). Here q is the number of completed segment-1 quanta and SJW = jump-width code + 1.
- R7: During a frame, an edge in segment 2 that is the first correction of the bit has phase error e = L2 − q. If e ≤ SJW, the bit ends in that cycle with a bit-end strobe and the next cycle starts a sync quantum. Otherwise segment 2 is shortened by SJW.
- R8: During a frame, an edge in the sync phase has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the quantum source |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration, reserved bits zero |
| rx_edge | input | 1 | One-cycle pulse on a recessive-to-dominant receive edge |
| bus_idle | input | 1 | High while no frame is in progress |
| tq_tick | output | 1 | Pulse in the last clock of each quantum |
| sample_pt | output | 1 | Pulse at the end of segment 1 |
| bit_end | output | 1 | Pulse at the end of each bit |
| cfg_err | output | 1 | Prohibited segment code present |

## Verification
The timing path is driven with configurations that differ in one dimension at a time. These are a minimum-length bit at full clock rate, maximum segments at prescale two, an odd prescaler with mid-length segments, and the full 10-bit prescaler. Each exposes a different off-by-one: in the quantum divider, in segment 1 or in segment 2. Each prohibited code is written on its own, which shows that the error decode covers each field separately. Edges are placed in the sync phase, early and late in segment 1, and at two depths in segment 2, under two jump widths. These placements separate the capped correction from the uncapped one and the shortened segment-2 case from the immediate-restart case. An idle-bus edge mid-bit shows that hard synchronisation differs from in-frame correction.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int CFG_W   = 32;
  localparam int BE_W    = CFG_W / 8;
  localparam int BRP_W   = 10;
  localparam int T1C_W   = 4;
  localparam int T2C_W   = 3;
  localparam int SJC_W   = 2;
  localparam int BRP_LSB = 0;
  localparam int T1_LSB  = 16;
  localparam int T2_LSB  = 20;
  localparam int SJ_LSB  = 24;
  localparam int LEN_W   = 5;   // wide enough for 16 + 4 quanta
  localparam int SJL_W   = 3;
  localparam int T1_MIN_CODE = 3;
  localparam logic [CFG_W-1:0] CFG_MASK =
      ({{(CFG_W-BRP_W){1'b0}}, {BRP_W{1'b1}}} << BRP_LSB) |
      ({{(CFG_W-T1C_W){1'b0}}, {T1C_W{1'b1}}} << T1_LSB)  |
      ({{(CFG_W-T2C_W){1'b0}}, {T2C_W{1'b1}}} << T2_LSB)  |
      ({{(CFG_W-SJC_W){1'b0}}, {SJC_W{1'b1}}} << SJ_LSB);

  typedef enum logic [1:0] {PH_SYNC = 2'd0, PH_SEG1 = 2'd1, PH_SEG2 = 2'd2} phase_e;

  typedef struct packed {
    logic [BRP_W-1:0] brp;
    logic [LEN_W-1:0] seg1_len;
    logic [LEN_W-1:0] seg2_len;
    logic [SJL_W-1:0] sjw_len;
  } timing_t;
endpackage

// File: rtl/can_bt_cfg_reg.sv
module can_bt_cfg_reg
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BE_W-1:0]  be,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output timing_t          tcfg,
  output logic             err
);
  logic [CFG_W-1:0] q;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[8*b +: 8] <= 8'h00;
      else if (wr && be[b]) q[8*b +: 8] <= wdata[8*b +: 8] & CFG_MASK[8*b +: 8];
    end
  end

  logic [T1C_W-1:0] t1c;
  logic [T2C_W-1:0] t2c;
  logic [SJC_W-1:0] sjc;

  always_comb begin
    t1c = q[T1_LSB +: T1C_W];
    t2c = q[T2_LSB +: T2C_W];
    sjc = q[SJ_LSB +: SJC_W];
    tcfg.brp      = q[BRP_LSB +: BRP_W];
    tcfg.seg1_len = LEN_W'(t1c) + LEN_W'(1);
    tcfg.seg2_len = LEN_W'(t2c) + LEN_W'(1);
    tcfg.sjw_len  = SJL_W'(sjc) + SJL_W'(1);
    err   = (t1c < T1C_W'(T1_MIN_CODE)) || (t2c == '0);
    rdata = q;
  end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp,
  output logic             tick
);
  logic [BRP_W-1:0] cnt;

  assign tick = en && (cnt >= brp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || restart)   cnt <= '0;
    else if (cnt >= brp)       cnt <= '0;
    else                       cnt <= cnt + BRP_W'(1);
  end

  a_r3_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/can_bt_segctl.sv
module can_bt_segctl
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             rx_edge,
  input  logic             bus_idle,
  input  logic [LEN_W-1:0] seg1_len,
  input  logic [LEN_W-1:0] seg2_len,
  input  logic [SJL_W-1:0] sjw_len,
  output logic             sample_pt,
  output logic             bit_end,
  output logic             restart
);
  phase_e           ph_q;
  logic [LEN_W-1:0] q_q;
  logic [SJL_W-1:0] ext_q, shr_q;
  logic             rsd_q;

  logic             hsync, take, take1, take2, rst2;
  logic [LEN_W-1:0] sjw5, e1, e2, ext_eff5, shr_eff5;
  logic [SJL_W-1:0] ext_new, ext_eff, shr_eff;
  logic             seg1_end, seg2_end;

  always_comb begin
    sjw5   = LEN_W'(sjw_len);
    hsync  = en && rx_edge && bus_idle;
    take   = en && rx_edge && !bus_idle && !rsd_q && (ph_q != PH_SYNC);
    take1  = take && (ph_q == PH_SEG1);
    take2  = take && (ph_q == PH_SEG2);
    e1     = q_q + LEN_W'(1);
    ext_new = (e1 < sjw5) ? e1[SJL_W-1:0] : sjw_len;
    e2     = seg2_len - q_q;
    rst2   = take2 && (e2 <= sjw5);
    ext_eff = take1 ? ext_new : ext_q;
    shr_eff = (take2 && !rst2) ? sjw_len : shr_q;
    ext_eff5 = LEN_W'(ext_eff);
    shr_eff5 = LEN_W'(shr_eff);
    seg1_end = tick && (ph_q == PH_SEG1) && (q_q + LEN_W'(1) >= seg1_len + ext_eff5);
    seg2_end = tick && (ph_q == PH_SEG2) && (q_q + LEN_W'(1) + shr_eff5 >= seg2_len);
    sample_pt = seg1_end && !hsync;
    bit_end   = (seg2_end || rst2) && !hsync;
    restart   = hsync || rst2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_SYNC; q_q <= '0; ext_q <= '0; shr_q <= '0; rsd_q <= 1'b0;
    end else if (!en || restart) begin
      ph_q <= PH_SYNC; q_q <= '0; ext_q <= '0; shr_q <= '0; rsd_q <= 1'b0;
    end else begin
      if (take1) begin
        ext_q <= ext_new;
        rsd_q <= 1'b1;
      end
      if (take2) begin
        shr_q <= sjw_len;
        rsd_q <= 1'b1;
      end
      if (tick) begin
        unique case (ph_q)
          PH_SYNC: begin
            ph_q <= PH_SEG1;
            q_q  <= '0;
          end
          PH_SEG1: begin
            if (seg1_end) begin
              ph_q <= PH_SEG2;
              q_q  <= '0;
            end else begin
              q_q <= q_q + LEN_W'(1);
            end
          end
          PH_SEG2: begin
            if (seg2_end) begin
              ph_q  <= PH_SYNC;
              q_q   <= '0;
              ext_q <= '0;
              shr_q <= '0;
              rsd_q <= 1'b0;
            end else begin
              q_q <= q_q + LEN_W'(1);
            end
          end
          default: begin
            ph_q <= PH_SYNC;
            q_q  <= '0;
          end
        endcase
      end
    end
  end

  a_r4_bitend_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (ph_q == PH_SYNC));
  a_r4_sample_then_seg2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && en) |=> ((ph_q == PH_SEG2) || (q_q == '0)));
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pt && bit_end));
  a_r6_ext_capped: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q <= SJL_W'(4));
  a_r5_hard_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> ((ph_q == PH_SYNC) && (q_q == '0)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx_edge,
  input  logic        bus_idle,
  output logic        tq_tick,
  output logic        sample_pt,
  output logic        bit_end,
  output logic        cfg_err
);
  timing_t tcfg;
  logic    restart;

  can_bt_cfg_reg i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .be(cfg_be), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .tcfg(tcfg), .err(cfg_err)
  );

  can_bt_prescaler i_pre (
    .clk(clk), .rst_n(rst_n), .en(!cfg_err), .restart(restart),
    .brp(tcfg.brp), .tick(tq_tick)
  );

  can_bt_segctl i_seg (
    .clk(clk), .rst_n(rst_n), .en(!cfg_err), .tick(tq_tick),
    .rx_edge(rx_edge), .bus_idle(bus_idle),
    .seg1_len(tcfg.seg1_len), .seg2_len(tcfg.seg2_len), .sjw_len(tcfg.sjw_len),
    .sample_pt(sample_pt), .bit_end(bit_end), .restart(restart)
  );

  a_r3_stopped_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(tq_tick || sample_pt || bit_end));
  a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CFG_MASK) == '0);
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rx_edge = 1'b0;
  logic        bus_idle = 1'b0;
  logic        tq_tick, sample_pt, bit_end, cfg_err;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_edge(rx_edge), .bus_idle(bus_idle),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end), .cfg_err(cfg_err)
  );

  // cfg word, expected error, first sample cycle, first bit-end cycle
  localparam logic [64:0] VEC [7] = '{
    {32'h0013_0000, 1'b0, 16'd5,    16'd7},
    {32'h037F_0001, 1'b0, 16'd34,   16'd50},
    {32'h0025_0002, 1'b0, 16'd21,   16'd30},
    {32'h0003_0004, 1'b1, 16'd0,    16'd0},
    {32'h0012_0000, 1'b1, 16'd0,    16'd0},
    {32'h0070_0000, 1'b1, 16'd0,    16'd0},
    {32'h0013_03FF, 1'b0, 16'd5120, 16'd7168}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [3:0] be, input logic [31:0] d);
    cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  // starts at the negedge of cycle 1; records strobe cycles
  task automatic measure(input int max_n, input int edge_at,
                         output int s1, output int s2, output int b1, output int b2);
    s1 = 0; s2 = 0; b1 = 0; b2 = 0;
    for (int n = 1; n <= max_n; n++) begin
      rx_edge = (n == edge_at);
      #1;
      if (sample_pt) begin if (s1 == 0) s1 = n; else if (s2 == 0) s2 = n; end
      if (bit_end)   begin if (b1 == 0) b1 = n; else if (b2 == 0) b2 = n; end
      @(negedge clk);
    end
    rx_edge = 1'b0;
  endtask

  task automatic fresh(input logic [31:0] d);
    wr_cfg(4'hF, 32'h0);
    wr_cfg(4'hF, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s1, s2, b1, b2, ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", int'(cfg_rdata), 0);
    check("R1 cfg_err", int'(cfg_err), 1);
    ticks = 0;
    for (int k = 0; k < 20; k++) begin
      #1; ticks += int'(tq_tick) + int'(sample_pt) + int'(bit_end);
      @(negedge clk);
    end
    check("R1 no strobes", ticks, 0);

    // R4 / R3 table walk
    foreach (VEC[i]) begin
      int mx;
      fresh(VEC[i][64:33]);
      check(VEC[i][32] ? "R3 err flag" : "R4 err flag", int'(cfg_err), int'(VEC[i][32]));
      mx = VEC[i][32] ? 300 : 2 * int'(VEC[i][15:0]) + 4;
      measure(mx, 0, s1, s2, b1, b2);
      if (VEC[i][32]) begin
        check("R3 no sample", s1, 0);
        check("R3 no bit end", b1, 0);
      end else begin
        check("R4 sample", s1, int'(VEC[i][31:16]));
        check("R4 bit end", b1, int'(VEC[i][15:0]));
        check("R4 second bit end", b2, 2 * int'(VEC[i][15:0]));
      end
    end

    // R2 byte lanes and reserved bits
    wr_cfg(4'hF, 32'hFFFF_FFFF);
    check("R2 reserved masked", int'(cfg_rdata), int'(32'h037F_03FF));
    wr_cfg(4'hF, 32'h0);
    wr_cfg(4'h4, 32'hFF23_FFFF);
    check("R2 lane2 only", int'(cfg_rdata), int'(32'h0023_0000));
    wr_cfg(4'h1, 32'hFFFF_FFFF);
    check("R2 lane0", int'(cfg_rdata), int'(32'h0023_00FF));
    wr_cfg(4'h2, 32'hFFFF_FFFF);
    check("R2 lane1 masked", int'(cfg_rdata), int'(32'h0023_03FF));

    // R8 edge in sync ignored (L1=8, L2=4, SJW=2, P=0)
    bus_idle = 1'b0;
    fresh(32'h0137_0000);
    measure(30, 1, s1, s2, b1, b2);
    check("R8 sample", s1, 9);
    check("R8 bit end", b1, 13);

    // R6 lengthening, capped and uncapped
    fresh(32'h0137_0000);
    measure(30, 3, s1, s2, b1, b2);
    check("R6 sample e2", s1, 11);
    check("R6 bit end e2", b1, 15);
    fresh(32'h0137_0000);
    measure(30, 6, s1, s2, b1, b2);
    check("R6 sample capped sjw2", s1, 11);
    fresh(32'h0337_0000);
    measure(30, 6, s1, s2, b1, b2);
    check("R6 sample sjw4", s1, 13);
    check("R6 bit end sjw4", b1, 17);

    // R7 shortening and immediate restart
    fresh(32'h0137_0000);
    measure(30, 11, s1, s2, b1, b2);
    check("R7 shortened bit end", b1, 11);
    check("R7 next sample", s2, 20);
    fresh(32'h0137_0000);
    measure(30, 12, s1, s2, b1, b2);
    check("R7 restart bit end", b1, 12);
    check("R7 restart next sample", s2, 21);

    // R5 hard sync while idle
    bus_idle = 1'b1;
    fresh(32'h0137_0000);
    measure(30, 5, s1, s2, b1, b2);
    check("R5 sample", s1, 14);
    check("R5 bit end", b1, 18);
    bus_idle = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule